// File: doc/BRIEF.md
# Packed-to-Planar Tile Converter

This block turns pixel data held one byte per pixel into the bitplane tile layout that a tile-based video pipeline fetches. A host fills a 16-byte staging file with two consecutive 8-pixel rows. Writing the final staging slot commits the pair. A sequencer then emits one destination byte per clock into a local tile RAM through a byte-wide write port. Each emitted byte collects one bit position of all eight pixels of one row. The leftmost pixel lands in bit 7.

A configuration write selects the colour depth (2, 4 or 8 bits per pixel) and the base address of a pair of tile slots. It also rewinds a 3-bit pair counter. The low two counter bits pick which rows of the tile the committed pair fills. The top bit picks one of two tile slots that sit back to back, so the host can fill one tile while the other is consumed. A pulse marks the last RAM write of every completed tile. While the sequencer is emitting, the block drops its ready output, and any host write presented in that time is discarded.

Top module: `tile_conv`

## Requirements
- R1: The depth code selects the bits per pixel: 0 gives 8, 1 gives 4, 2 and 3 both give 2. One commit produces 2 × (bits per pixel) RAM writes, covering both staged rows.
- R2: A tile spans 8 × (bits per pixel) bytes. When the pair counter's top bit is set, addresses are offset by one tile size from the configured base.
- R3: Each written byte holds bit k of the eight pixels of one row. Pixel 0 (staging slot 0, or slot 8 for the second row) goes in bit 7, and pixel 7 goes in bit 0.
- R4: Bit k of a pixel in tile row n is written at base + 2n + 16·(k div 2) + (k mod 2), plus the slot offset of R2. Staging slots 0..7 form tile row 2·c and slots 8..15 form tile row 2·c+1, where c is the pair counter's low two bits.
- R5: An accepted write to staging slot 15 starts the conversion. The first RAM write appears in the cycle after that write is accepted, and writes follow on consecutive cycles: row 2·c first, bit index ascending within each row.
- R6: The 3-bit pair counter increments modulo 8 after each commit finishes. An accepted configuration write resets it to 0.
- R7: `ready` is low exactly while RAM writes are being emitted. Staging and configuration writes presented while `ready` is low have no effect.
- R8: `tile_done` is high together with the last RAM write of a commit whose pair counter's low two bits are 3, and is low in all other cycles.
- R9: RAM addresses wrap modulo 2048.
- R10: Pixel bits at or above the selected depth are never written to the RAM.
- R11: After reset, `ready` is high, no RAM write is issued, the depth code is 0, the base is 0 and the pair counter is 0.
- R12: When a configuration write and a write to slot 15 are accepted in the same cycle, the commit uses the new depth, the new base and a pair counter of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_we | input | 1 | Staging write strobe |
| stg_idx | input | 4 | Staging slot index; slot 15 commits |
| stg_data | input | 8 | Packed pixel byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_depth | input | 2 | Depth code (see R1) |
| cfg_base | input | 11 | Base address of the two tile slots |
| ready | output | 1 | High when host writes are accepted |
| ram_we | output | 1 | Tile RAM write strobe |
| ram_addr | output | 11 | Tile RAM byte address |
| ram_wdata | output | 8 | Planar byte |
| tile_done | output | 1 | Final write of a full tile |

## Verification
The bench builds the block with its default parameters: 16 staging slots, 8-bit pixels and an 11-bit RAM address. With these values, a base near the top of the 2 KB space makes the tile addresses run past the end and wrap within a few writes. All three depths are reachable, and eight commits take the pair counter around once, across both tile slots. A behavioural model holds a queue of expected RAM writes and compares it with the outputs on every clock. This includes the writes that the bench deliberately presents while the block is busy.

// File: rtl/tile_conv_pkg.sv
package tile_conv_pkg;

    typedef enum logic [1:0] {
        DEPTH_8BPP = 2'd0,
        DEPTH_4BPP = 2'd1,
        DEPTH_2BPP = 2'd2,
        DEPTH_2ALT = 2'd3
    } depth_code_e;

    // Number of bitplanes for a depth code.
    function automatic logic [3:0] planes_of(input logic [1:0] code);
        logic [3:0] n;
        case (depth_code_e'(code))
            DEPTH_8BPP: n = 4'd8;
            DEPTH_4BPP: n = 4'd4;
            default:    n = 4'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tile_conv_stage.sv
module tile_conv_stage #(
    parameter  int STG_N   = 16,
    parameter  int PIX_W   = 8,
    localparam int IDX_W   = $clog2(STG_N),
    localparam int ROW_PIX = STG_N / 2,
    localparam int PL_W    = $clog2(PIX_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PIX_W-1:0]   wr_data,
    input  logic               hold_i,
    input  logic               row_sel,
    input  logic [PL_W-1:0]    plane_sel,
    output logic [ROW_PIX-1:0] plane_byte,
    output logic               commit
);

    logic [STG_N-1:0][PIX_W-1:0] bytes_d, bytes_q;

    always_comb begin
        bytes_d = bytes_q;
        if (wr_en) begin
            bytes_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else begin
            bytes_q <= bytes_d;
        end
    end

    assign commit = wr_en && (wr_idx == IDX_W'(STG_N - 1));

    // Gather one bit position across a row; leftmost pixel to the MSB.
    for (genvar p = 0; p < ROW_PIX; p++) begin : g_gather
        assign plane_byte[ROW_PIX-1-p] = row_sel ? bytes_q[ROW_PIX+p][plane_sel]
                                                 : bytes_q[p][plane_sel];
    end

    // Staging contents must not move while the sequencer reads them.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(bytes_q));

endmodule

// File: rtl/tile_conv_addr.sv
module tile_conv_addr #(
    parameter int RAM_AW = 11
) (
    input  logic [RAM_AW-1:0] base,
    input  logic [1:0]        dcode,
    input  logic [2:0]        pair,
    input  logic              row,
    input  logic [2:0]        plane,
    output logic [RAM_AW-1:0] addr
);
    import tile_conv_pkg::*;

    logic [RAM_AW-1:0] tile_bytes;
    logic [RAM_AW-1:0] slot_off;
    logic [RAM_AW-1:0] row_off;
    logic [RAM_AW-1:0] plane_off;

    always_comb begin
        tile_bytes = RAM_AW'(planes_of(dcode)) << 3;
        slot_off   = pair[2] ? tile_bytes : '0;
        row_off    = RAM_AW'({pair[1:0], row}) << 1;
        plane_off  = (RAM_AW'(plane[2:1]) << 4) | RAM_AW'(plane[0]);
        addr       = base + slot_off + row_off + plane_off;
    end

endmodule

// File: rtl/tile_conv_seq.sv
module tile_conv_seq #(
    parameter  int RAM_AW  = 11,
    parameter  int ROW_PIX = 8,
    localparam int PL_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [1:0]         cfg_depth,
    input  logic [RAM_AW-1:0]  cfg_base,
    input  logic               commit,
    input  logic [ROW_PIX-1:0] plane_byte,
    output logic               busy,
    output logic               row_sel,
    output logic [PL_W-1:0]    plane_sel,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [ROW_PIX-1:0] ram_wdata,
    output logic               tile_done
);
    import tile_conv_pkg::*;

    typedef struct packed {
        logic              busy;
        logic              row;
        logic [PL_W-1:0]   plane;
        logic [2:0]        pair;
        logic [1:0]        dcode;
        logic [RAM_AW-1:0] base;
    } seq_t;

    seq_t s_d, s_q;
    logic [PL_W-1:0] plane_last;
    logic            row_end;
    logic            last_beat;

    always_comb begin
        plane_last = PL_W'(planes_of(s_q.dcode) - 4'd1);
        row_end    = s_q.plane == plane_last;
        last_beat  = s_q.busy && s_q.row && row_end;

        s_d = s_q;
        if (s_q.busy) begin
            if (row_end) begin
                s_d.plane = '0;
                if (s_q.row) begin
                    s_d.busy = 1'b0;
                    s_d.row  = 1'b0;
                    s_d.pair = s_q.pair + 3'd1;
                end else begin
                    s_d.row = 1'b1;
                end
            end else begin
                s_d.plane = s_q.plane + PL_W'(1);
            end
        end
        if (cfg_en) begin
            s_d.dcode = cfg_depth;
            s_d.base  = cfg_base;
            s_d.pair  = '0;
        end
        if (commit) begin
            s_d.busy  = 1'b1;
            s_d.row   = 1'b0;
            s_d.plane = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    tile_conv_addr #(.RAM_AW(RAM_AW)) u_addr (
        .base  (s_q.base),
        .dcode (s_q.dcode),
        .pair  (s_q.pair),
        .row   (s_q.row),
        .plane (s_q.plane),
        .addr  (ram_addr)
    );

    assign busy      = s_q.busy;
    assign row_sel   = s_q.row;
    assign plane_sel = s_q.plane;
    assign ram_we    = s_q.busy;
    assign ram_wdata = plane_byte;
    assign tile_done = last_beat && (s_q.pair[1:0] == 2'b11);

    // Even plane inside a row: its odd partner sits one byte higher.
    assert_addr_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.plane[0] && !row_end) |=> (ram_addr == $past(ram_addr) + RAM_AW'(1)));

    assert_plane_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.plane <= plane_last));

    assert_pair_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> (s_q.pair == $past(s_q.pair) + 3'd1));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tile_done |=> !tile_done);

endmodule

// File: rtl/tile_conv.sv
module tile_conv #(
    parameter  int STG_N   = 16,
    parameter  int PIX_W   = 8,
    parameter  int RAM_AW  = 11,
    localparam int IDX_W   = $clog2(STG_N),
    localparam int ROW_PIX = STG_N / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stg_we,
    input  logic [IDX_W-1:0]   stg_idx,
    input  logic [PIX_W-1:0]   stg_data,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_depth,
    input  logic [RAM_AW-1:0]  cfg_base,
    output logic               ready,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [ROW_PIX-1:0] ram_wdata,
    output logic               tile_done
);

    logic               busy;
    logic               stg_en;
    logic               cfg_en;
    logic               commit;
    logic               row_sel;
    logic [2:0]         plane_sel;
    logic [ROW_PIX-1:0] plane_byte;

    assign ready  = !busy;
    assign stg_en = stg_we && ready;
    assign cfg_en = cfg_we && ready;

    tile_conv_stage #(.STG_N(STG_N), .PIX_W(PIX_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (stg_en),
        .wr_idx     (stg_idx),
        .wr_data    (stg_data),
        .hold_i     (busy),
        .row_sel    (row_sel),
        .plane_sel  (plane_sel),
        .plane_byte (plane_byte),
        .commit     (commit)
    );

    tile_conv_seq #(.RAM_AW(RAM_AW), .ROW_PIX(ROW_PIX)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_depth  (cfg_depth),
        .cfg_base   (cfg_base),
        .commit     (commit),
        .plane_byte (plane_byte),
        .busy       (busy),
        .row_sel    (row_sel),
        .plane_sel  (plane_sel),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .tile_done  (tile_done)
    );

endmodule

// File: tb/tile_conv_bench.sv
module tile_conv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stg_we = 1'b0;
    logic [3:0]  stg_idx = '0;
    logic [7:0]  stg_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_depth = '0;
    logic [10:0] cfg_base = '0;
    logic        ready, ram_we, tile_done;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_conv u_tile_conv (
        .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_idx(stg_idx),
        .stg_data(stg_data), .cfg_we(cfg_we), .cfg_depth(cfg_depth),
        .cfg_base(cfg_base), .ready(ready), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .tile_done(tile_done)
    );

    typedef struct { int addr; int data; bit done; } beat_t;
    beat_t q[$];
    int    m_stg[16];
    int    m_code, m_base, m_cnt;
    int    checks = 0, errors = 0;
    string phase = "R11 reset";
    bit    finished = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, act, exp);
        end
    endtask

    // Expected writes of one committed row pair (R1..R4, R8..R10).
    task automatic push_commit();
        int d = (m_code == 0) ? 8 : (m_code == 1) ? 4 : 2;
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < d; k++) begin
                beat_t b;
                b.addr = (m_base + (m_cnt / 4) * 8 * d + ((m_cnt % 4) * 2 + r) * 2
                          + (k / 2) * 16 + (k % 2)) % 2048;
                b.data = 0;
                for (int p = 0; p < 8; p++)
                    b.data = b.data | (((m_stg[r*8+p] >> k) & 1) << (7 - p));
                b.done = (r == 1) && (k == d - 1) && ((m_cnt % 4) == 3);
                q.push_back(b);
            end
        end
        m_cnt = (m_cnt + 1) % 8;
    endtask

    always @(posedge clk) begin
        bit acc;
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < 16; i++) m_stg[i] = 0;
            m_code = 0; m_base = 0; m_cnt = 0;
        end else begin
            acc = (q.size() == 0);
            if (q.size() > 0) void'(q.pop_front());
            if (acc) begin
                if (cfg_we) begin
                    m_code = int'(cfg_depth); m_base = int'(cfg_base); m_cnt = 0;
                end
                if (stg_we) begin
                    m_stg[stg_idx] = int'(stg_data);
                    if (stg_idx == 4'd15) push_commit();
                end
            end
        end
    end

    always @(negedge clk) begin
        bit exp_we;
        if (!finished) begin
            if (!rst_n) begin
                chk(ready == 1'b1, "R11 ready", int'(ready), 1);
                chk(ram_we == 1'b0, "R11 write strobe", int'(ram_we), 0);
                chk(tile_done == 1'b0, "R11 tile done", int'(tile_done), 0);
            end else begin
                exp_we = (q.size() > 0);
                chk(ram_we == exp_we, "R5 write strobe", int'(ram_we), int'(exp_we));
                chk(ready == !exp_we, "R7 ready", int'(ready), int'(!exp_we));
                if (exp_we) begin
                    chk(int'(ram_addr) == q[0].addr, "R4 R2 R9 address", int'(ram_addr), q[0].addr);
                    chk(int'(ram_wdata) == q[0].data, "R3 R10 plane byte", int'(ram_wdata), q[0].data);
                    chk(tile_done == q[0].done, "R8 tile done", int'(tile_done), int'(q[0].done));
                end else begin
                    chk(tile_done == 1'b0, "R8 tile done idle", int'(tile_done), 0);
                end
            end
        end
    end

    function automatic logic [7:0] pat(int s, int i);
        return 8'((s * 73 + i * 29 + 11) & 255);
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic wr_stg(int idx, logic [7:0] v);
        wait_ready();
        stg_we = 1'b1; stg_idx = 4'(idx); stg_data = v;
        @(negedge clk);
        stg_we = 1'b0;
    endtask

    task automatic do_cfg(int code, int base);
        wait_ready();
        cfg_we = 1'b1; cfg_depth = 2'(code); cfg_base = 11'(base);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill_pair(int seed);
        for (int i = 0; i < 16; i++) wr_stg(i, pat(seed, i));
    endtask

    task automatic fill_const(logic [7:0] v);
        for (int i = 0; i < 16; i++) wr_stg(i, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1 R2 R6 R8 depth 8, two tiles";
        do_cfg(0, 11'h100);
        for (int t = 0; t < 8; t++) fill_pair(t);

        phase = "R9 R1 depth 4, wrap at 2 KB";
        do_cfg(1, 11'h7F0);
        for (int t = 0; t < 4; t++) fill_pair(t + 10);

        phase = "R10 depth 2, upper pixel bits";
        do_cfg(2, 11'h040);
        fill_const(8'hFF);
        fill_const(8'hFC);
        fill_pair(31);

        phase = "R1 depth code 3";
        do_cfg(3, 11'h200);
        fill_pair(40);
        fill_pair(41);

        phase = "R7 writes while busy ignored";
        do_cfg(0, 11'h300);
        fill_pair(50);
        stg_we = 1'b1; stg_idx = 4'd0; stg_data = 8'hAA;
        cfg_we = 1'b1; cfg_depth = 2'd2; cfg_base = 11'h000;
        repeat (4) @(negedge clk);
        stg_we = 1'b0; cfg_we = 1'b0;
        wr_stg(15, pat(50, 15));
        wr_stg(15, 8'h5A);

        phase = "R6 config rewinds counter";
        do_cfg(1, 11'h400);
        fill_pair(60);
        fill_pair(61);

        phase = "R12 config and commit together";
        wait_ready();
        stg_we = 1'b1; stg_idx = 4'd15; stg_data = 8'h3C;
        cfg_we = 1'b1; cfg_depth = 2'd1; cfg_base = 11'h123;
        @(negedge clk);
        stg_we = 1'b0; cfg_we = 1'b0;

        wait_ready();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog [%s]: actual %0d expected %0d", phase, WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule